// File: doc/BRIEF.md
# Data Address Translation Fault Unit

This block wraps the translation lookaside lookup of a load/store pipeline. Each cycle it may receive one data request: a 64-bit virtual address, an access size, a write flag, request qualifiers (physical, page-table-entry load, no-fault, alternate mode) and the result of a lookup that was done elsewhere (hit flag, physical page number, per-mode read and write enables, and fault-on-read and fault-on-write bits). One cycle later it returns either a physical address or a fault code.

Several rules decide the result, and they are applied in a fixed order. A misaligned address fails first. A physical request then passes straight through. A kernel-only window maps virtual addresses directly to physical ones and sign-extends the result. Otherwise the lookup result is used: a miss gives a miss fault, and a hit goes through the permission and fault-on checks. Any physical address outside the implemented range gives a machine check.

When a translation or protection fault is logged, three status registers are written. They hold the faulting address, a packed status word and a formatted address that points into the page table. Page-table-entry loads and no-fault requests never write these registers.

Top module: `dxlate_fault_unit`

## Requirements
- R1: An address with `reqVa & ((1<<reqSize)-1)` nonzero (reqSize is log2 of the byte count, 0..3) yields fault code 1 (misaligned), ahead of every other rule. It never writes the status registers.
- R2: An aligned request with `reqPhys` set returns PA = VA unchanged, with fault code 0, when VA bits 63:44 are zero.
- R3: A non-physical aligned address whose bits 47:41 equal 0x7E is in the direct window. If the effective mode is not kernel (0), the result is fault code 2 (access violation) with cause bits write (if writing) and violation.
- R4: In the direct window with kernel effective mode, PA = VA bits 43:0. If PA bit 40 is set, bits 43:40 are forced to 1. Otherwise the PA is cut to bits 39:0.
- R5: On a lookup miss outside the window, the fault code is 4 if `reqPteLoad` is set and 5 otherwise. The cause bits are miss and write (if writing).
- R6: A write hit whose write enable for the effective mode is clear gives code 2 with cause write+violation, plus fault-on-write if that bit is set. If the enable is set but fault-on-write is set, the result is code 3 with cause write+fault-on-write.
- R7: A read hit whose read enable is clear gives code 2 with cause violation, plus fault-on-read if that bit is set. If the enable is set but fault-on-read is set, the result is code 3 with cause fault-on-read.
- R8: A logged fault stores `mmStatus` as follows: opcode at bits 16:11, destination register at bits 10:6, cause at bits 5:0. The cause bits are write=bit0, violation=bit1, fault-on-read=bit2, fault-on-write=bit3, miss=bit4. The faulting VA goes into `faultVa`.
- R9: A logged fault stores `faultVaForm = pteBaseReg | ((VA >> 13) << 3)`.
- R10: The status registers stay unchanged when a request is a page-table-entry load or carries `reqNoFault`.
- R11: When `pcPriv` is set, the effective mode is kernel, or `altModeReg` when `reqAltMode` is set. Otherwise it is `curMode`. Modes are kernel 0, executive 1, supervisor 2, user 3, and each mode indexes the bit of the same number in the enable vectors.
- R12: A physical-request or hit PA with any bit above bit 43 set gives fault code 6 (machine check), and the status registers are not written.
- R13: On a hit that passes every check, PA = (PPN << 13) | VA[12:0] with code 0. Each response appears one cycle after its request with `rspValid` high and `rspPaddr` zero on any fault. With no request, `rspValid` is low and the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqVa | input | 64 | Virtual address |
| reqSize | input | 2 | Log2 of access size in bytes |
| reqWrite | input | 1 | Store when high |
| reqPhys | input | 1 | Address is already physical |
| reqPteLoad | input | 1 | Page-table-entry load |
| reqNoFault | input | 1 | Do not log faults |
| reqAltMode | input | 1 | Use alternate mode while privileged |
| pcPriv | input | 1 | Fetch PC is in privileged firmware |
| curMode | input | 2 | Current processor mode |
| altModeReg | input | 2 | Alternate mode value |
| instOpcode | input | 6 | Opcode of the faulting instruction |
| instReg | input | 5 | Destination register number |
| pteBaseReg | input | 64 | Page-table base for formatted VA |
| tlbHit | input | 1 | Lookup hit |
| tlbPpn | input | 32 | Physical page number |
| tlbReadEn | input | 4 | Per-mode read enables |
| tlbWriteEn | input | 4 | Per-mode write enables |
| tlbFaultOnRead | input | 1 | Fault-on-read bit |
| tlbFaultOnWrite | input | 1 | Fault-on-write bit |
| rspValid | output | 1 | Response present |
| rspFault | output | 3 | Fault code (0 = none) |
| rspPaddr | output | 64 | Physical address, zero on fault |
| faultVa | output | 64 | Last logged faulting VA |
| mmStatus | output | 17 | Last logged status word |
| faultVaForm | output | 64 | Last logged formatted VA |

## Verification
The assertions assume that the lookup fields (hit, page number, enables, fault-on bits) belong to the same cycle as the request they qualify. They also assume that the mode and qualifier inputs stay fixed while a request is presented, so each response can be matched to the single request one cycle earlier. The stimulus drives every request field together on the falling edge and holds it for exactly one cycle. Window addresses, out-of-range pages and misaligned offsets are built on purpose inside the random mix, so every rule is reached while the inputs stay in that form.

// File: rtl/dxf_pkg.sv
package dxf_pkg;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_ALIGN     = 3'd1,
    FLT_ACV       = 3'd2,
    FLT_FAULT     = 3'd3,
    FLT_MISS_PRIM = 3'd4,
    FLT_MISS      = 3'd5,
    FLT_MCHECK    = 3'd6
  } fault_e;

  typedef enum logic [1:0] {
    MODE_KERNEL = 2'd0,
    MODE_EXEC   = 2'd1,
    MODE_SUPER  = 2'd2,
    MODE_USER   = 2'd3
  } mode_e;

  localparam int CAUSE_W    = 6;
  localparam int CAUSE_WR   = 0;
  localparam int CAUSE_ACV  = 1;
  localparam int CAUSE_FONR = 2;
  localparam int CAUSE_FONW = 3;
  localparam int CAUSE_MISS = 4;

  typedef enum logic [1:0] {
    PA_NONE = 2'd0,
    PA_PHYS = 2'd1,
    PA_WIN  = 2'd2,
    PA_HIT  = 2'd3
  } pa_sel_e;

  // datapath -> control: address-derived conditions
  typedef struct packed {
    logic misaligned;
    logic inWindow;
    logic physOutRange;
    logic hitOutRange;
  } dp_flags_t;

  // control -> datapath: strobes
  typedef struct packed {
    logic                capture;
    pa_sel_e             paSel;
    logic                logFault;
    logic [CAUSE_W-1:0]  cause;
  } strobe_t;

endpackage

// File: rtl/dxf_ctrl.sv
module dxf_ctrl
  import dxf_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqPhys,
  input  logic              reqPteLoad,
  input  logic              reqNoFault,
  input  logic              reqAltMode,
  input  logic              pcPriv,
  input  logic [MODE_W-1:0] curMode,
  input  logic [MODE_W-1:0] altModeReg,
  input  logic              tlbHit,
  input  logic [(1<<MODE_W)-1:0] tlbReadEn,
  input  logic [(1<<MODE_W)-1:0] tlbWriteEn,
  input  logic              tlbFaultOnRead,
  input  logic              tlbFaultOnWrite,
  input  dp_flags_t         flags,
  output strobe_t           stb,
  output logic              rspValid,
  output fault_e            rspFault
);

  logic [MODE_W-1:0]  effMode;
  logic               modeIsKernel;
  fault_e             faultNext;
  logic               wantsLog;
  logic [CAUSE_W-1:0] causeNext;
  pa_sel_e            selNext;

  // effective mode: firmware runs as kernel unless the alternate mode is asked for
  always_comb begin
    if (pcPriv) effMode = reqAltMode ? altModeReg : MODE_W'(MODE_KERNEL);
    else        effMode = curMode;
  end

  assign modeIsKernel = (effMode == MODE_W'(MODE_KERNEL));

  // ordered decision chain
  always_comb begin
    faultNext = FLT_NONE;
    wantsLog  = 1'b0;
    causeNext = '0;
    selNext   = PA_NONE;
    if (flags.misaligned) begin
      faultNext = FLT_ALIGN;
    end else if (reqPhys) begin
      if (flags.physOutRange) faultNext = FLT_MCHECK;
      else                    selNext   = PA_PHYS;
    end else if (flags.inWindow) begin
      if (!modeIsKernel) begin
        faultNext             = FLT_ACV;
        wantsLog              = 1'b1;
        causeNext[CAUSE_WR]   = reqWrite;
        causeNext[CAUSE_ACV]  = 1'b1;
      end else begin
        selNext = PA_WIN;
      end
    end else if (!tlbHit) begin
      faultNext             = reqPteLoad ? FLT_MISS_PRIM : FLT_MISS;
      wantsLog              = 1'b1;
      causeNext[CAUSE_WR]   = reqWrite;
      causeNext[CAUSE_MISS] = 1'b1;
    end else if (reqWrite) begin
      causeNext[CAUSE_WR] = 1'b1;
      if (!tlbWriteEn[effMode]) begin
        faultNext              = FLT_ACV;
        wantsLog               = 1'b1;
        causeNext[CAUSE_ACV]   = 1'b1;
        causeNext[CAUSE_FONW]  = tlbFaultOnWrite;
      end else if (tlbFaultOnWrite) begin
        faultNext              = FLT_FAULT;
        wantsLog               = 1'b1;
        causeNext[CAUSE_FONW]  = 1'b1;
      end else if (flags.hitOutRange) begin
        faultNext = FLT_MCHECK;
      end else begin
        selNext = PA_HIT;
      end
    end else begin
      if (!tlbReadEn[effMode]) begin
        faultNext              = FLT_ACV;
        wantsLog               = 1'b1;
        causeNext[CAUSE_ACV]   = 1'b1;
        causeNext[CAUSE_FONR]  = tlbFaultOnRead;
      end else if (tlbFaultOnRead) begin
        faultNext              = FLT_FAULT;
        wantsLog               = 1'b1;
        causeNext[CAUSE_FONR]  = 1'b1;
      end else if (flags.hitOutRange) begin
        faultNext = FLT_MCHECK;
      end else begin
        selNext = PA_HIT;
      end
    end
  end

  always_comb begin
    stb.capture  = reqValid;
    stb.paSel    = reqValid ? selNext : PA_NONE;
    stb.logFault = reqValid && wantsLog && !reqPteLoad && !reqNoFault;
    stb.cause    = causeNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= FLT_NONE;
    end else begin
      rspValid <= reqValid;
      rspFault <= reqValid ? faultNext : FLT_NONE;
    end
  end

endmodule

// File: rtl/dxf_dpath.sv
module dxf_dpath
  import dxf_pkg::*;
#(
  parameter int VA_W         = 64,
  parameter int SIZE_W       = 2,
  parameter int PAGE_BITS    = 13,
  parameter int PPN_W        = 32,
  parameter int PA_IMPL      = 44,
  parameter int EXT_BIT      = 40,
  parameter int WIN_LO       = 41,
  parameter int WIN_HI       = 47,
  parameter int WIN_TAG      = 126,
  parameter bit SIGN_EXT_WIN = 1'b1,
  parameter int PTE_SHIFT    = 3,
  parameter int OPC_W        = 6,
  parameter int REG_W        = 5,
  parameter int STAT_W       = OPC_W + REG_W + CAUSE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [PPN_W-1:0]  tlbPpn,
  input  logic [OPC_W-1:0]  instOpcode,
  input  logic [REG_W-1:0]  instReg,
  input  logic [VA_W-1:0]   pteBaseReg,
  input  strobe_t           stb,
  output dp_flags_t         flags,
  output logic [VA_W-1:0]   rspPaddr,
  output logic [VA_W-1:0]   faultVa,
  output logic [STAT_W-1:0] mmStatus,
  output logic [VA_W-1:0]   faultVaForm
);

  localparam int OFS_W = (1 << SIZE_W) - 1;
  localparam int WIN_W = WIN_HI - WIN_LO + 1;
  localparam logic [VA_W-1:0] IMPL_MASK = {{(VA_W-PA_IMPL){1'b0}}, {PA_IMPL{1'b1}}};
  localparam logic [VA_W-1:0] LOW_MASK  = {{(VA_W-EXT_BIT){1'b0}}, {EXT_BIT{1'b1}}};
  localparam logic [VA_W-1:0] EXT_ONES  = IMPL_MASK & ~LOW_MASK;
  localparam logic [VA_W-1:0] PAGE_MASK = {{(VA_W-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};

  logic [OFS_W-1:0] sizeMask;
  logic [VA_W-1:0]  winRaw;
  logic [VA_W-1:0]  winPa;
  logic [VA_W-1:0]  hitPa;
  logic [VA_W-1:0]  paNext;
  logic [VA_W-1:0]  formNext;

  assign sizeMask = OFS_W'((1 << reqSize) - 1);
  assign winRaw   = reqVa & IMPL_MASK;
  assign hitPa    = (VA_W'(tlbPpn) << PAGE_BITS) | (reqVa & PAGE_MASK);
  assign formNext = pteBaseReg | ((reqVa >> PAGE_BITS) << PTE_SHIFT);

  generate
    if (SIGN_EXT_WIN) begin : g_winExt
      always_comb winPa = winRaw[EXT_BIT] ? (winRaw | EXT_ONES) : (winRaw & LOW_MASK);
    end else begin : g_winFlat
      assign winPa = winRaw;
    end
  endgenerate

  always_comb begin
    flags.misaligned   = |(reqVa[OFS_W-1:0] & sizeMask);
    flags.inWindow     = (reqVa[WIN_HI:WIN_LO] == WIN_W'(WIN_TAG));
    flags.physOutRange = |(reqVa & ~IMPL_MASK);
    flags.hitOutRange  = |(hitPa & ~IMPL_MASK);
  end

  always_comb begin
    unique case (stb.paSel)
      PA_PHYS: paNext = reqVa;
      PA_WIN:  paNext = winPa;
      PA_HIT:  paNext = hitPa;
      default: paNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPaddr <= '0;
    end else begin
      rspPaddr <= stb.capture ? paNext : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultVa     <= '0;
      mmStatus    <= '0;
      faultVaForm <= '0;
    end else if (stb.logFault) begin
      faultVa     <= reqVa;
      mmStatus    <= {instOpcode, instReg, stb.cause};
      faultVaForm <= formNext;
    end
  end

endmodule

// File: rtl/dxlate_fault_unit.sv
module dxlate_fault_unit
  import dxf_pkg::*;
#(
  parameter int VA_W         = 64,
  parameter int SIZE_W       = 2,
  parameter int MODE_W       = 2,
  parameter int PAGE_BITS    = 13,
  parameter int PPN_W        = 32,
  parameter int PA_IMPL      = 44,
  parameter int EXT_BIT      = 40,
  parameter int WIN_LO       = 41,
  parameter int WIN_HI       = 47,
  parameter int WIN_TAG      = 126,
  parameter bit SIGN_EXT_WIN = 1'b1,
  parameter int PTE_SHIFT    = 3,
  parameter int OPC_W        = 6,
  parameter int REG_W        = 5,
  localparam int NMODES      = 1 << MODE_W,
  localparam int STAT_W      = OPC_W + REG_W + CAUSE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqWrite,
  input  logic              reqPhys,
  input  logic              reqPteLoad,
  input  logic              reqNoFault,
  input  logic              reqAltMode,
  input  logic              pcPriv,
  input  logic [MODE_W-1:0] curMode,
  input  logic [MODE_W-1:0] altModeReg,
  input  logic [OPC_W-1:0]  instOpcode,
  input  logic [REG_W-1:0]  instReg,
  input  logic [VA_W-1:0]   pteBaseReg,
  input  logic              tlbHit,
  input  logic [PPN_W-1:0]  tlbPpn,
  input  logic [NMODES-1:0] tlbReadEn,
  input  logic [NMODES-1:0] tlbWriteEn,
  input  logic              tlbFaultOnRead,
  input  logic              tlbFaultOnWrite,
  output logic              rspValid,
  output logic [2:0]        rspFault,
  output logic [VA_W-1:0]   rspPaddr,
  output logic [VA_W-1:0]   faultVa,
  output logic [STAT_W-1:0] mmStatus,
  output logic [VA_W-1:0]   faultVaForm
);

  dp_flags_t flags;
  strobe_t   stb;
  fault_e    faultCode;

  dxf_ctrl #(.MODE_W(MODE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPhys(reqPhys), .reqPteLoad(reqPteLoad), .reqNoFault(reqNoFault),
    .reqAltMode(reqAltMode), .pcPriv(pcPriv), .curMode(curMode),
    .altModeReg(altModeReg), .tlbHit(tlbHit), .tlbReadEn(tlbReadEn),
    .tlbWriteEn(tlbWriteEn), .tlbFaultOnRead(tlbFaultOnRead),
    .tlbFaultOnWrite(tlbFaultOnWrite), .flags(flags), .stb(stb),
    .rspValid(rspValid), .rspFault(faultCode)
  );

  dxf_dpath #(
    .VA_W(VA_W), .SIZE_W(SIZE_W), .PAGE_BITS(PAGE_BITS), .PPN_W(PPN_W),
    .PA_IMPL(PA_IMPL), .EXT_BIT(EXT_BIT), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
    .WIN_TAG(WIN_TAG), .SIGN_EXT_WIN(SIGN_EXT_WIN), .PTE_SHIFT(PTE_SHIFT),
    .OPC_W(OPC_W), .REG_W(REG_W), .STAT_W(STAT_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .reqVa(reqVa), .reqSize(reqSize), .tlbPpn(tlbPpn),
    .instOpcode(instOpcode), .instReg(instReg), .pteBaseReg(pteBaseReg),
    .stb(stb), .flags(flags), .rspPaddr(rspPaddr), .faultVa(faultVa),
    .mmStatus(mmStatus), .faultVaForm(faultVaForm)
  );

  assign rspFault = faultCode;

endmodule

// File: rtl/dxf_checker.sv
module dxf_checker #(
  parameter int VA_W    = 64,
  parameter int SIZE_W  = 2,
  parameter int MODE_W  = 2,
  parameter int PA_IMPL = 44,
  parameter int EXT_BIT = 40,
  parameter int WIN_LO  = 41,
  parameter int WIN_HI  = 47,
  parameter int WIN_TAG = 126,
  parameter int STAT_W  = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [VA_W-1:0]   reqVa,
  input logic [SIZE_W-1:0] reqSize,
  input logic              reqPhys,
  input logic              reqPteLoad,
  input logic              reqNoFault,
  input logic              pcPriv,
  input logic [MODE_W-1:0] curMode,
  input logic              rspValid,
  input logic [2:0]        rspFault,
  input logic [VA_W-1:0]   rspPaddr,
  input logic [VA_W-1:0]   faultVa,
  input logic [STAT_W-1:0] mmStatus,
  input logic [VA_W-1:0]   faultVaForm
);

  localparam int OFS_W = (1 << SIZE_W) - 1;
  localparam int WIN_W = WIN_HI - WIN_LO + 1;

  logic [OFS_W-1:0] offMask;
  logic             isAligned;
  logic             highClear;
  logic             inWin;
  logic [PA_IMPL-EXT_BIT-1:0] extField;

  assign offMask   = OFS_W'((1 << reqSize) - 1);
  assign isAligned = ((reqVa[OFS_W-1:0] & offMask) == '0);
  assign highClear = ((reqVa >> PA_IMPL) == '0);
  assign inWin     = (reqVa[WIN_HI:WIN_LO] == WIN_W'(WIN_TAG));
  assign extField  = rspPaddr[PA_IMPL-1:EXT_BIT];

  a_r1_align_first: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !isAligned |=> rspValid && rspFault == 3'd1);

  a_r2_phys_pass: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && isAligned && reqPhys && highClear |=>
      rspFault == 3'd0 && rspPaddr == $past(reqVa));

  a_r4_window_ext: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && isAligned && !reqPhys && inWin && !pcPriv && curMode == '0 |=>
      rspFault == 3'd0 && (extField == '0 || extField == '1));

  a_r10_quiet_regs: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (reqPteLoad || reqNoFault) |=>
      $stable(faultVa) && $stable(mmStatus) && $stable(faultVaForm));

  a_r12_pa_in_range: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault == 3'd0 |-> (rspPaddr >> PA_IMPL) == '0);

  a_r13_zero_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault != 3'd0 |-> rspPaddr == '0);

  a_r13_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid && rspFault == 3'd0);

endmodule

bind dxlate_fault_unit dxf_checker #(
  .VA_W(VA_W), .SIZE_W(SIZE_W), .MODE_W(MODE_W), .PA_IMPL(PA_IMPL),
  .EXT_BIT(EXT_BIT), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .WIN_TAG(WIN_TAG),
  .STAT_W(STAT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa),
  .reqSize(reqSize), .reqPhys(reqPhys), .reqPteLoad(reqPteLoad),
  .reqNoFault(reqNoFault), .pcPriv(pcPriv), .curMode(curMode),
  .rspValid(rspValid), .rspFault(rspFault), .rspPaddr(rspPaddr),
  .faultVa(faultVa), .mmStatus(mmStatus), .faultVaForm(faultVaForm)
);

// File: tb/dxlate_fault_unit_tb_top.sv
module dxlate_fault_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 0;
  logic [63:0] reqVa = 0;
  logic [1:0]  reqSize = 0;
  logic        reqWrite = 0, reqPhys = 0, reqPteLoad = 0, reqNoFault = 0;
  logic        reqAltMode = 0, pcPriv = 0;
  logic [1:0]  curMode = 0, altModeReg = 0;
  logic [5:0]  instOpcode = 0;
  logic [4:0]  instReg = 0;
  logic [63:0] pteBaseReg = 0;
  logic        tlbHit = 0;
  logic [31:0] tlbPpn = 0;
  logic [3:0]  tlbReadEn = 0, tlbWriteEn = 0;
  logic        tlbFaultOnRead = 0, tlbFaultOnWrite = 0;
  logic        rspValid;
  logic [2:0]  rspFault;
  logic [63:0] rspPaddr, faultVa, faultVaForm;
  logic [16:0] mmStatus;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state of the status registers
  logic [63:0] mFaultVa = 0, mForm = 0;
  logic [16:0] mStat = 0;

  always #10 clk = ~clk;

  dxlate_fault_unit dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqPhys(reqPhys),
    .reqPteLoad(reqPteLoad), .reqNoFault(reqNoFault), .reqAltMode(reqAltMode),
    .pcPriv(pcPriv), .curMode(curMode), .altModeReg(altModeReg),
    .instOpcode(instOpcode), .instReg(instReg), .pteBaseReg(pteBaseReg),
    .tlbHit(tlbHit), .tlbPpn(tlbPpn), .tlbReadEn(tlbReadEn),
    .tlbWriteEn(tlbWriteEn), .tlbFaultOnRead(tlbFaultOnRead),
    .tlbFaultOnWrite(tlbFaultOnWrite), .rspValid(rspValid),
    .rspFault(rspFault), .rspPaddr(rspPaddr), .faultVa(faultVa),
    .mmStatus(mmStatus), .faultVaForm(faultVaForm)
  );

  task automatic check64(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clearReq();
    reqValid = 0; reqVa = 0; reqSize = 0; reqWrite = 0; reqPhys = 0;
    reqPteLoad = 0; reqNoFault = 0; reqAltMode = 0; pcPriv = 0;
    curMode = 0; altModeReg = 0; tlbHit = 0; tlbPpn = 0;
    tlbReadEn = 4'hF; tlbWriteEn = 4'hF; tlbFaultOnRead = 0; tlbFaultOnWrite = 0;
  endtask

  // Called on a falling edge with the request fields already set.
  task automatic step();
    int          eCode;
    logic [63:0] ePa;
    logic [5:0]  eCause;
    bit          eLog;
    string       tag;
    logic [1:0]  mode;
    logic [63:0] pa;
    eCode = 0; ePa = 0; eCause = 0; eLog = 0; tag = "R13";
    mode = pcPriv ? (reqAltMode ? altModeReg : 2'd0) : curMode;
    if (!reqValid) begin
      tag = "R13";
    end else if ((reqVa & ((64'd1 << reqSize) - 64'd1)) != 0) begin
      eCode = 1; tag = "R1";
    end else if (reqPhys) begin
      if (reqVa[63:44] != 0) begin eCode = 6; tag = "R12"; end
      else begin ePa = reqVa; tag = "R2"; end
    end else if (reqVa[47:41] == 7'h7E) begin
      if (mode != 0) begin
        eCode = 2; eLog = 1; eCause = {4'b0, 1'b1, reqWrite};
        tag = pcPriv ? "R11" : "R3";
      end else begin
        pa = {20'h0, reqVa[43:0]};
        if (pa[40]) pa[43:40] = 4'hF; else pa = {24'h0, pa[39:0]};
        ePa = pa; tag = pcPriv ? "R11" : "R4";
      end
    end else if (!tlbHit) begin
      eCode = reqPteLoad ? 4 : 5; eLog = 1; eCause = {1'b0, 1'b1, 3'b0, reqWrite};
      tag = "R5";
    end else begin
      pa = ({32'h0, tlbPpn} * 64'd8192) + {51'h0, reqVa[12:0]};
      if (reqWrite) begin
        tag = "R6";
        if (tlbWriteEn[mode] == 1'b0) begin
          eCode = 2; eLog = 1; eCause = {2'b0, tlbFaultOnWrite, 1'b0, 1'b1, 1'b1};
        end else if (tlbFaultOnWrite) begin
          eCode = 3; eLog = 1; eCause = 6'b001001;
        end
      end else begin
        tag = "R7";
        if (tlbReadEn[mode] == 1'b0) begin
          eCode = 2; eLog = 1; eCause = {3'b0, tlbFaultOnRead, 1'b1, 1'b0};
        end else if (tlbFaultOnRead) begin
          eCode = 3; eLog = 1; eCause = 6'b000100;
        end
      end
      if (eCode == 0) begin
        if (pa[63:44] != 0) begin eCode = 6; tag = "R12"; end
        else begin ePa = pa; if (pcPriv) tag = "R11"; else tag = "R13"; end
      end else if (pcPriv) tag = "R11";
    end
    if (reqValid && eLog && !reqPteLoad && !reqNoFault) begin
      mFaultVa = reqVa;
      mStat    = 17'(instOpcode) * 17'd2048 + 17'(instReg) * 17'd64 + 17'(eCause);
      mForm    = pteBaseReg | ((reqVa / 64'd8192) * 64'd8);
    end
    @(negedge clk);
    check64("R13", "rspValid", 64'(rspValid), 64'(reqValid));
    check64(tag, "rspFault", 64'(rspFault), 64'(eCode));
    check64(tag, "rspPaddr", rspPaddr, ePa);
    check64((reqPteLoad || reqNoFault) ? "R10" : "R8", "faultVa", faultVa, mFaultVa);
    check64((reqPteLoad || reqNoFault) ? "R10" : "R8", "mmStatus", 64'(mmStatus), 64'(mStat));
    check64((reqPteLoad || reqNoFault) ? "R10" : "R9", "faultVaForm", faultVaForm, mForm);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    clearReq();
    instOpcode = 6'h2C; instReg = 5'h11; pteBaseReg = 64'hFFFF_FE00_0000_0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state (R13)
    check64("R13", "reset rspValid", 64'(rspValid), 64'd0);
    check64("R13", "reset faultVa", faultVa, 64'd0);
    check64("R13", "reset mmStatus", 64'(mmStatus), 64'd0);

    // R1: misaligned wins over physical and window
    clearReq(); reqValid = 1; reqPhys = 1; reqSize = 2; reqVa = 64'h1002; step();
    clearReq(); reqValid = 1; reqSize = 3; reqVa = 64'h0000_FC00_0000_0004; curMode = 3; step();
    // R2 passthrough, R12 out of range
    clearReq(); reqValid = 1; reqPhys = 1; reqSize = 3; reqVa = 64'h0000_0123_4567_8AB8; step();
    clearReq(); reqValid = 1; reqPhys = 1; reqVa = 64'h0004_0000_0000_0010; step();
    // R4 window, bit 40 set and clear
    clearReq(); reqValid = 1; reqVa = 64'h0000_FD23_4567_8000; step();
    clearReq(); reqValid = 1; reqVa = 64'h0000_FCC3_4567_8000; step();
    // R3 window in user mode, write
    clearReq(); reqValid = 1; reqWrite = 1; curMode = 3; reqVa = 64'h0000_FD00_0000_0040; step();
    // R11 privileged PC: kernel by default, alternate mode when asked
    clearReq(); reqValid = 1; pcPriv = 1; curMode = 3; reqVa = 64'h0000_FD00_0000_0080; step();
    clearReq(); reqValid = 1; pcPriv = 1; reqAltMode = 1; altModeReg = 2; curMode = 0;
    reqVa = 64'h0000_FD00_0000_00C0; step();
    // R5 misses
    clearReq(); reqValid = 1; reqVa = 64'h0000_0000_4000_2000; step();
    clearReq(); reqValid = 1; reqWrite = 1; reqPteLoad = 1; reqVa = 64'h0000_0000_5000_2000; step();
    // R10 no-fault miss
    clearReq(); reqValid = 1; reqNoFault = 1; reqVa = 64'h0000_0000_6000_0000; step();
    // R13 hit, R7 read checks
    clearReq(); reqValid = 1; tlbHit = 1; tlbPpn = 32'h0012_3456; reqVa = 64'h0000_0000_7000_1ABC; reqSize = 2; step();
    clearReq(); reqValid = 1; tlbHit = 1; curMode = 3; tlbReadEn = 4'b0111; tlbFaultOnRead = 1; reqVa = 64'h8000; step();
    clearReq(); reqValid = 1; tlbHit = 1; tlbFaultOnRead = 1; reqVa = 64'h9000; step();
    // R6 write checks
    clearReq(); reqValid = 1; reqWrite = 1; tlbHit = 1; curMode = 1; tlbWriteEn = 4'b1101; tlbFaultOnWrite = 1; reqVa = 64'hA000; step();
    clearReq(); reqValid = 1; reqWrite = 1; tlbHit = 1; tlbFaultOnWrite = 1; reqVa = 64'hB000; step();
    // R12 hit page beyond range
    clearReq(); reqValid = 1; tlbHit = 1; tlbPpn = 32'h8000_0001; reqVa = 64'hC000; step();
    // idle
    clearReq(); step();

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      clearReq();
      reqValid   = ($urandom % 8) != 0;
      reqVa      = {$urandom, $urandom};
      case ($urandom % 4)
        0: reqVa[47:41] = 7'h7E;
        1: reqVa[63:44] = 20'h0;
        2: reqVa[63:32] = 32'h0;
        default: ;
      endcase
      if (($urandom % 3) != 0) reqVa[2:0] = 3'b000;
      reqSize    = 2'($urandom);
      reqWrite   = 1'($urandom);
      reqPhys    = ($urandom % 5) == 0;
      reqPteLoad = ($urandom % 6) == 0;
      reqNoFault = ($urandom % 6) == 0;
      reqAltMode = 1'($urandom);
      pcPriv     = ($urandom % 4) == 0;
      curMode    = 2'($urandom);
      altModeReg = 2'($urandom);
      instOpcode = 6'($urandom);
      instReg    = 5'($urandom);
      pteBaseReg = {$urandom, $urandom} & ~64'hFFFF_FFFF;
      tlbHit     = ($urandom % 4) != 0;
      tlbPpn     = ($urandom % 8 == 0) ? $urandom : ($urandom & 32'h7FFF_FFFF);
      tlbReadEn  = 4'($urandom) | 4'b0001;
      tlbWriteEn = 4'($urandom);
      tlbFaultOnRead  = ($urandom % 5) == 0;
      tlbFaultOnWrite = ($urandom % 5) == 0;
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule